// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block guards a clock-frequency change. Software sets the enable and then asks for a new frequency. The frequency logic reports the change with a one-cycle pulse, and that pulse arms a countdown. The countdown runs in coarse units: a short unit or a long unit, picked by a prescaler select bit. The units come from a slow time-base tick, which a parameterised divider turns into unit boundaries. Software is expected to confirm that the system survived the change by clearing the enable before the count runs out.

If the count runs out, the block does three things:
- It sets a sticky status flag.
- It raises a recovery flag. The surrounding logic uses this flag to load a safe frequency and to ignore further software frequency requests.
- If enabled, it pulls an open-drain, active-low system reset low for a fixed number of ticks.

The recovery lock stays until software clears the enable. A second reset enable produces the same reset pulse on every accepted frequency change.

Top module: `wdog_recovery_ctrl`

## Requirements
- R1: After reset, `status_o` and `recovery_o` are 0, `rst_pull_low_o` is 0, and the reset pad is released.
- R2: With `wd_en_i`=1, an accepted `freq_change_i` pulse arms the countdown. Expiry happens on the (T+1)·U-th tick after arming. T is `wd_timeout_i`. U is SHORT_UNIT_TICKS when `wd_prescale_i`=0 and LONG_UNIT_TICKS when it is 1. `status_o` and `recovery_o` rise in the cycle after that tick.
- R3: A frequency change accepted while the countdown runs restarts the countdown from the full length.
- R4: The timeout field and the prescaler select are sampled when the countdown arms. Later changes have no effect until the next arming.
- R5: Clearing `wd_en_i` stops the countdown and releases `recovery_o` in the next cycle. `status_o` is not affected.
- R6: `status_o` is sticky. `status_clr_i`=1 clears it in the next cycle, `status_clr_i`=0 leaves it unchanged, and an expiry in the same cycle as a clear wins.
- R7: While `recovery_o`=1, `freq_change_i` is ignored. It neither arms the countdown nor starts a reset pulse.
- R8: Entering recovery does not arm the countdown again. No further expiry occurs until a new frequency change is accepted.
- R9: With `rst_on_expire_en_i`=1, an expiry starts a reset pulse. The pulse lasts until RST_PULSE_TICKS ticks have passed after the trigger. With the enable at 0, an expiry gives no pulse.
- R10: With `rst_on_fchg_en_i`=1, every accepted frequency change starts the same reset pulse, whether or not `wd_en_i` is set.
- R11: `rst_pull_low_o` is 1 exactly while the pulse is active. During that time `sys_rst_n_o` is driven to 0; at all other times it is high-impedance.
- R12: A new trigger during an active pulse restarts the full pulse length.
- R13: A tick in the same cycle as arming is not counted toward the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_en_i | input | 1 | Watchdog enable; 0 stops the countdown and releases recovery |
| wd_timeout_i | input | TMO_W | Timeout field T; the countdown lasts T+1 units |
| wd_prescale_i | input | 1 | Unit select: 0 short, 1 long |
| rst_on_expire_en_i | input | 1 | Enables the reset pulse on expiry |
| rst_on_fchg_en_i | input | 1 | Enables the reset pulse on a frequency change |
| status_clr_i | input | 1 | Write-one strobe that clears the status flag |
| freq_change_i | input | 1 | One-cycle pulse reporting a frequency change |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| status_o | output | 1 | Sticky expiry status |
| recovery_o | output | 1 | Recovery lock flag |
| rst_pull_low_o | output | 1 | High while the reset pad is pulled low |
| sys_rst_n_o | output | 1 | Open-drain reset pad: 0 or high-impedance |

## Verification
The bench builds the block with SHORT_UNIT_TICKS=3, LONG_UNIT_TICKS=5 and RST_PULSE_TICKS=4. These values keep the two unit sizes distinct and the pulse length short. They also let even a full 32-unit countdown finish in a few hundred cycles. As a result, the maximum timeout field, re-arming partway through a long count, and a pulse restarting near its end are all reached many times in one run. A bench model counts the total ticks since arming against (T+1)·U and is compared with the outputs every cycle.

// File: rtl/wdr_pkg.sv
package wdr_pkg;

  // Countdown length in units for a timeout field value.
  function automatic int unsigned units_for(int unsigned field);
    return field + 1;
  endfunction

  // Unit length in base ticks for a prescaler select.
  function automatic int unsigned unit_ticks(bit long_sel, int unsigned short_len,
                                             int unsigned long_len);
    return long_sel ? long_len : short_len;
  endfunction

endpackage

// File: rtl/wdr_unit_divider.sv
module wdr_unit_divider #(
  parameter int unsigned SHORT_TICKS = 150,
  parameter int unsigned LONG_TICKS  = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic long_sel_i,
  output logic unit_done_o
);
  localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int unsigned DIV_W = $clog2(MAX_TICKS + 1);
  localparam logic [DIV_W-1:0] SHORT_LAST =
    DIV_W'(wdr_pkg::unit_ticks(1'b0, SHORT_TICKS, LONG_TICKS) - 1);
  localparam logic [DIV_W-1:0] LONG_LAST =
    DIV_W'(wdr_pkg::unit_ticks(1'b1, SHORT_TICKS, LONG_TICKS) - 1);

  logic [DIV_W-1:0] cnt_q;
  logic             at_last;

  assign at_last     = (cnt_q == (long_sel_i ? LONG_LAST : SHORT_LAST));
  assign unit_done_o = run_i & tick_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown #(
  parameter int unsigned TMO_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             stop_i,
  input  logic             unit_done_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             long_sel_i,
  output logic             running_o,
  output logic             long_sel_q_o,
  output logic             last_unit_o
);
  localparam int unsigned CNT_W = TMO_W + 1;

  logic [CNT_W-1:0] units_q;

  assign last_unit_o = (units_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_o    <= 1'b0;
      units_q      <= '0;
      long_sel_q_o <= 1'b0;
    end else if (stop_i) begin
      running_o <= 1'b0;
    end else if (arm_i) begin
      running_o    <= 1'b1;
      units_q      <= CNT_W'(wdr_pkg::units_for(32'(timeout_i)));
      long_sel_q_o <= long_sel_i;
    end else if (running_o && unit_done_i) begin
      if (last_unit_o) running_o <= 1'b0;
      else             units_q   <= units_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdr_pulse_stretch.sv
module wdr_pulse_stretch #(
  parameter int unsigned LEN_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic tick_i,
  output logic active_o
);
  localparam int unsigned LEN_W = $clog2(LEN_TICKS + 1);
  localparam logic [LEN_W-1:0] LEN_LOAD = LEN_W'(LEN_TICKS);

  logic [LEN_W-1:0] left_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 left_q <= '0;
    else if (trig_i)             left_q <= LEN_LOAD;
    else if (active_o && tick_i) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/wdog_recovery_ctrl.sv
module wdog_recovery_ctrl #(
  parameter int unsigned TMO_W            = 5,
  parameter int unsigned SHORT_UNIT_TICKS = 150,
  parameter int unsigned LONG_UNIT_TICKS  = 2500,
  parameter int unsigned RST_PULSE_TICKS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wd_en_i,
  input  logic [TMO_W-1:0] wd_timeout_i,
  input  logic             wd_prescale_i,
  input  logic             rst_on_expire_en_i,
  input  logic             rst_on_fchg_en_i,
  input  logic             status_clr_i,
  input  logic             freq_change_i,
  input  logic             tick_i,
  output logic             status_o,
  output logic             recovery_o,
  output logic             rst_pull_low_o,
  output logic             sys_rst_n_o
);
  // Named internal events, observed by the bound checker.
  logic fchg_evt;
  logic arm_evt;
  logic unit_done;
  logic last_unit;
  logic running;
  logic long_sel_q;
  logic expire_evt;
  logic rst_trig;

  assign fchg_evt   = freq_change_i & ~recovery_o;
  assign arm_evt    = fchg_evt & wd_en_i;
  assign expire_evt = unit_done & last_unit & wd_en_i & ~arm_evt;
  assign rst_trig   = (expire_evt & rst_on_expire_en_i) | (fchg_evt & rst_on_fchg_en_i);

  wdr_unit_divider #(
    .SHORT_TICKS(SHORT_UNIT_TICKS),
    .LONG_TICKS (LONG_UNIT_TICKS)
  ) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (arm_evt | ~wd_en_i),
    .run_i      (running),
    .tick_i     (tick_i),
    .long_sel_i (long_sel_q),
    .unit_done_o(unit_done)
  );

  wdr_countdown #(.TMO_W(TMO_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm_evt),
    .stop_i      (~wd_en_i),
    .unit_done_i (unit_done),
    .timeout_i   (wd_timeout_i),
    .long_sel_i  (wd_prescale_i),
    .running_o   (running),
    .long_sel_q_o(long_sel_q),
    .last_unit_o (last_unit)
  );

  wdr_pulse_stretch #(.LEN_TICKS(RST_PULSE_TICKS)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (rst_trig),
    .tick_i  (tick_i),
    .active_o(rst_pull_low_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          recovery_o <= 1'b0;
    else if (!wd_en_i)    recovery_o <= 1'b0;
    else if (expire_evt)  recovery_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           status_o <= 1'b0;
    else if (expire_evt)   status_o <= 1'b1;
    else if (status_clr_i) status_o <= 1'b0;
  end

  assign sys_rst_n_o = rst_pull_low_o ? 1'b0 : 1'bz;
endmodule

// File: rtl/wdog_recovery_ctrl_chk.sv
module wdog_recovery_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wd_en_i,
  input logic status_clr_i,
  input logic status_o,
  input logic recovery_o,
  input logic rst_pull_low_o,
  input logic running,
  input logic expire_evt,
  input logic rst_trig
);
  assert_expire_sets_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_evt |=> status_o);

  assert_clear_status_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && status_clr_i && !expire_evt) |=> !status_o);

  assert_disable_releases_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i |=> !recovery_o);

  assert_recovery_from_expiry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recovery_o) |-> $past(expire_evt));

  assert_locked_not_running_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recovery_o |-> !running);

  assert_expire_needs_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_evt |-> running);

  assert_pulse_has_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_pull_low_o) |-> $past(rst_trig));
endmodule

bind wdog_recovery_ctrl wdog_recovery_ctrl_chk u_chk (.*);

// File: tb/wdog_recovery_ctrl_bench.sv
module wdog_recovery_ctrl_bench;
  localparam int SHORT_U = 3;
  localparam int LONG_U  = 5;
  localparam int PULSE   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, ps = 0, ren_exp = 0, ren_fc = 0, clr = 0, fchg = 0, tick = 0;
  logic [4:0] tmo = 5'h1f;
  logic status, recov, pull;
  wire  pad;

  int tests = 0, fails = 0;
  string phase = "R1";

  // Reference model state.
  bit m_run = 0, m_rec = 0, m_stat = 0;
  int m_ticks = 0, m_need = 0, m_left = 0;

  always #2.5 clk = ~clk;

  wdog_recovery_ctrl #(
    .TMO_W(5), .SHORT_UNIT_TICKS(SHORT_U), .LONG_UNIT_TICKS(LONG_U),
    .RST_PULSE_TICKS(PULSE)
  ) u_wdog_recovery_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wd_en_i(en), .wd_timeout_i(tmo),
    .wd_prescale_i(ps), .rst_on_expire_en_i(ren_exp), .rst_on_fchg_en_i(ren_fc),
    .status_clr_i(clr), .freq_change_i(fchg), .tick_i(tick),
    .status_o(status), .recovery_o(recov), .rst_pull_low_o(pull), .sys_rst_n_o(pad)
  );

  function automatic int need_ticks(int field, bit long_sel);
    return (field + 1) * (long_sel ? LONG_U : SHORT_U);
  endfunction

  always @(posedge clk) begin
    bit fc, ex;
    fc = fchg && !m_rec;
    ex = 0;
    if (!rst_n) begin
      m_run = 0; m_rec = 0; m_stat = 0; m_left = 0; m_ticks = 0;
    end else begin
      if (!en) begin
        m_run = 0; m_rec = 0;
      end else if (fc) begin
        m_run = 1; m_ticks = 0; m_need = need_ticks(int'(tmo), ps);
      end else if (m_run && tick) begin
        m_ticks++;
        if (m_ticks == m_need) begin m_run = 0; m_rec = 1; ex = 1; end
      end
      if (ex) m_stat = 1;
      else if (clr) m_stat = 0;
      if ((ex && ren_exp) || (fc && ren_fc)) m_left = PULSE;
      else if (m_left > 0 && tick) m_left--;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check({phase, " status"}, status, m_stat);
    check({phase, " recovery"}, recov, m_rec);
    check({phase, " pulse"}, pull, logic'(m_left > 0));
    if (m_left > 0) check("R11 pad low", pad, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
    tick = 0;
  endtask

  task automatic pulse_fc();
    fchg = 1; cyc(); fchg = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    check("R1 status", status, 1'b0);
    check("R1 recovery", recov, 1'b0);
    check("R1 pull", pull, 1'b0);

    // R2 / R13: arm with a coinciding tick, T=2, short unit -> 9 ticks.
    phase = "R2"; en = 1; ps = 0; tmo = 5'd2;
    tick = 1; pulse_fc(); tick = 0;
    ticks(need_ticks(2, 0) - 1);
    check("R13 not yet", status, 1'b0);
    ticks(1);
    check("R2 status", status, 1'b1);
    check("R2 recovery", recov, 1'b1);

    // R7: change ignored while locked.
    phase = "R7"; ren_fc = 1; pulse_fc();
    check("R7 no pulse", pull, 1'b0);
    ren_fc = 0;

    // R5: disable releases lock, status kept; R6: clear.
    phase = "R5"; en = 0; cyc();
    check("R5 released", recov, 1'b0);
    check("R5 status kept", status, 1'b1);
    phase = "R6"; clr = 1; cyc(); clr = 0;
    check("R6 cleared", status, 1'b0);

    // R3 / R4: long unit T=1 (10 ticks), re-arm after 6, change fields.
    phase = "R3"; en = 1; ps = 1; tmo = 5'd1; pulse_fc();
    tmo = 5'd31; ps = 0;
    ticks(6);
    tmo = 5'd1; ps = 1; pulse_fc();
    phase = "R4"; tmo = 5'd0; ps = 0;
    ticks(need_ticks(1, 1) - 1);
    check("R3 restart", status, 1'b0);
    ticks(1);
    check("R4 sampled", status, 1'b1);

    // R9 / R11: reset on expiry.
    phase = "R9"; en = 0; clr = 1; cyc(); clr = 0; en = 1;
    ren_exp = 1; tmo = 5'd0; ps = 0; pulse_fc();
    ticks(need_ticks(0, 0));
    check("R9 pulse on", pull, 1'b1);
    check("R11 pad", pad, 1'b0);
    ticks(PULSE - 1);
    check("R9 still on", pull, 1'b1);
    ticks(1);
    check("R9 pulse off", pull, 1'b0);

    // R8: no re-arm after expiry.
    phase = "R8"; clr = 1; cyc(); clr = 0;
    ticks(60);
    check("R8 stays clear", status, 1'b0);

    // R10 / R12: reset on change without watchdog, restarted.
    phase = "R10"; en = 0; ren_exp = 0; ren_fc = 1; cyc();
    pulse_fc();
    check("R10 pulse on", pull, 1'b1);
    ticks(2);
    phase = "R12"; pulse_fc();
    ticks(PULSE - 1);
    check("R12 extended", pull, 1'b1);
    ticks(1);
    check("R12 off", pull, 1'b0);
    ren_fc = 0;

    // Constrained random mix.
    phase = "random R2 R6 R9";
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 2) == 0;
      fchg = ($urandom % 150) == 0;
      clr  = ($urandom % 40) == 0;
      if (($urandom % 300) == 0) en = ~en;
      else if (!en && ($urandom % 20) == 0) en = 1;
      if (($urandom % 50) == 0) begin
        tmo = (($urandom % 8) == 0) ? 5'd31 : 5'($urandom % 8);
        ps = $urandom % 2;
        ren_exp = $urandom % 2;
        ren_fc = ($urandom % 4) == 0;
      end
      cyc();
    end
    tick = 0; fchg = 0; clr = 0;
    cyc();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule